// File: doc/BRIEF.md
# Wired Interrupt to Vector Message Converter

This block takes a set of wired interrupt lines and turns each active one into a message carrying an 8-bit vector number, delivered on a valid/ready port to an upstream interrupt controller. Each line can be made edge or level sensitive, and its active sense can be high/rising or low/falling. Each line has its own mask bit, its own message-enable bit, a programmable vector byte and a route byte. Edge events are held in a sticky pending bit until the message for them is accepted, or until software discards them through a write-one-to-clear register.

Software programs the block over a simple 32-bit register bus. A write takes one cycle and uses byte enables. A read returns data on the cycle after the request. Lines are grouped 32 to a word, so line n is bit n%32 of word n/32, and each further word sits 4 bytes above the one before it. When several lines are eligible at once, the lowest-numbered line is sent first.

Top module: `wvec_ctrl`

## Requirements
- R1: After reset, every mask bit reads 1 and every message-enable bit reads 1. The edge-select and polarity words read 0. The word at offset 0x04 reads 0x003F0000: bits 23:16 hold the line count minus one, which is bits 55:48 of the 64-bit identification word at offset 0. The word at offset 0x00 reads 0.
- R2: Each bit register is a pair of words at base and base+4, with line n at word n/32, bit n%32. The bases are: mask 0x20, message-enable 0x40, edge-select 0x60, clear 0x80, polarity 0x3E0. The route bytes are at 0x100+n and the vector bytes at 0x200+n, with line n in byte lane n%4 of its word.
- R3: A line whose mask bit is 1 produces no message. Clearing the mask bit to 0 lets it through, including an edge that was latched while the line was masked.
- R4: With edge-select 0, a line is level sensitive. A polarity of 0 means active high and a polarity of 1 means active low. Messages for the line repeat for as long as it stays active and unmasked, and stop once it goes inactive.
- R5: With edge-select 1, a rising edge (polarity 0) or a falling edge (polarity 1) sets a sticky pending bit. The line then produces exactly one message, and the pending bit clears when that message is accepted.
- R6: Writing 1 to a bit of the clear register discards that line's pending edge. Writing 0 has no effect. The clear register reads as 0.
- R7: A line whose message-enable bit is 0 produces no message. Setting the bit to 1 lets it through.
- R8: The vector of a message is the line's vector byte. Byte writes change only the lanes whose byte enable is set.
- R9: When several lines are eligible at the same time, messages are sent in ascending order of line number.
- R10: While msg_valid is 1 and msg_ready is 0, msg_valid stays 1 and msg_vector stays unchanged.
- R11: The route bytes and the two auxiliary words at 0xC0 and 0xE0 are read/write storage only and have no effect on messages. Offsets that are not mapped read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | N_IN (64) | Asynchronous wired interrupt lines |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe; data appears the next cycle |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| msg_valid | output | 1 | A vector message is offered |
| msg_vector | output | 8 | Vector number of the offered message |
| msg_ready | input | 1 | Upstream accepts the message when high together with msg_valid |

## Verification
The assertions assume that msg_ready is a plain level, and that the bus never issues a read and a write in the same cycle. They also assume that irq_in is sampled only through the synchronizer, so an edge may reach the pending logic at any cycle. The stimulus keeps to these assumptions. It drives every bus access and every ready pulse at the falling clock edge, one operation at a time. It holds each interrupt pulse for several cycles, so that the pulse survives the two synchronizer stages. It lets a deasserted level line drain any message already offered before it checks that no further message comes.

// File: rtl/wvec_pkg.sv
package wvec_pkg;
  localparam int DATA_W = 32;
  localparam int BUS_AW = 12;
  localparam int WIDX_W = BUS_AW - 2;

  // word indices (byte offset / 4)
  localparam logic [WIDX_W-1:0] W_ID    = 10'd0;
  localparam logic [WIDX_W-1:0] W_MASK  = 10'd8;
  localparam logic [WIDX_W-1:0] W_MEN   = 10'd16;
  localparam logic [WIDX_W-1:0] W_EDGE  = 10'd24;
  localparam logic [WIDX_W-1:0] W_CLR   = 10'd32;
  localparam logic [WIDX_W-1:0] W_AUXA  = 10'd48;
  localparam logic [WIDX_W-1:0] W_AUXB  = 10'd56;
  localparam logic [WIDX_W-1:0] W_ROUTE = 10'd64;
  localparam logic [WIDX_W-1:0] W_VEC   = 10'd128;
  localparam logic [WIDX_W-1:0] W_POL   = 10'd248;

  function automatic logic [DATA_W-1:0] be_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [DATA_W-1:0] merge_word(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [3:0] be);
    return (old_w & ~be_mask(be)) | (new_w & be_mask(be));
  endfunction
endpackage

// File: rtl/wvec_sync.sv
module wvec_sync #(
  parameter int N_IN   = 64,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] d_async,
  output logic [N_IN-1:0] d_sync
);
  logic [N_IN-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_async;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign d_sync = stg_q[STAGES-1];
endmodule

// File: rtl/wvec_trig.sv
module wvec_trig #(
  parameter int N_IN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_IN-1:0] line_sync,
  input  logic [N_IN-1:0] edge_sel,
  input  logic [N_IN-1:0] pol_inv,
  input  logic [N_IN-1:0] clr_pulse,
  input  logic [N_IN-1:0] ack_pulse,
  output logic [N_IN-1:0] req
);
  logic [N_IN-1:0] active;
  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] pend_q;
  logic [N_IN-1:0] new_edge;

  assign active   = line_sync ^ pol_inv;
  assign new_edge = active & ~prev_q & edge_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= active;
      // a fresh edge wins over a clear or an accept in the same cycle
      pend_q <= (pend_q & ~clr_pulse & ~ack_pulse) | new_edge;
    end
  end

  assign req = pend_q | (active & ~edge_sel);

  // R6
  clr_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr_pulse & ~new_edge)) |=> ((pend_q & $past(clr_pulse & ~new_edge)) == '0));

  // R5
  pend_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~$past(pend_q) & ~$past(edge_sel)) == '0));
endmodule

// File: rtl/wvec_arb.sv
module wvec_arb #(
  parameter int N_IN = 64,
  localparam int IW = $clog2(N_IN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   req,
  input  logic [N_IN-1:0]   mask,
  input  logic [N_IN-1:0]   men,
  input  logic [N_IN*8-1:0] vec_flat,
  input  logic              msg_ready,
  output logic              msg_valid,
  output logic [7:0]        msg_vector,
  output logic [N_IN-1:0]   ack_pulse
);
  logic [N_IN-1:0] elig;
  logic [IW-1:0]   sel;
  logic [IW-1:0]   idx_q;
  logic            valid_q;
  logic [7:0]      vec_q;

  assign elig = req & ~mask & men;

  always_comb begin
    sel = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (elig[i]) sel = IW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      idx_q   <= '0;
    end else if (valid_q && msg_ready) begin
      valid_q <= 1'b0;
    end else if (!valid_q && (|elig)) begin
      valid_q <= 1'b1;
      vec_q   <= vec_flat[{sel, 3'b000} +: 8];
      idx_q   <= sel;
    end
  end

  assign ack_pulse  = (valid_q && msg_ready) ? ({{(N_IN-1){1'b0}}, 1'b1} << idx_q) : '0;
  assign msg_valid  = valid_q;
  assign msg_vector = vec_q;

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !msg_ready) |=> (valid_q && $stable(vec_q) && $stable(idx_q)));

  // R9
  lowest_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> (($past(elig) & (({{(N_IN-1){1'b0}}, 1'b1} << idx_q) - 1'b1)) == '0));

  // R3
  load_eligible_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> (($past(elig) >> idx_q) & {{(N_IN-1){1'b0}}, 1'b1}) != '0);
endmodule

// File: rtl/wvec_regs.sv
module wvec_regs
  import wvec_pkg::*;
#(
  parameter int N_IN = 64,
  localparam int NW = N_IN / DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_IN-1:0]   mask_o,
  output logic [N_IN-1:0]   men_o,
  output logic [N_IN-1:0]   edge_o,
  output logic [N_IN-1:0]   pol_o,
  output logic [N_IN-1:0]   clr_o,
  output logic [N_IN*8-1:0] vec_flat
);
  logic [WIDX_W-1:0] waddr;
  logic [N_IN-1:0]   mask_q, men_q, edge_q, pol_q;
  logic [DATA_W-1:0] auxa_q [NW];
  logic [DATA_W-1:0] auxb_q [NW];
  logic [7:0]        route_q [N_IN];
  logic [7:0]        vec_q   [N_IN];
  logic [DATA_W-1:0] rmux;
  logic [DATA_W-1:0] rdata_q;

  localparam logic [7:0] ID_CNT = 8'(N_IN - 1);

  assign waddr = bus_addr[BUS_AW-1:2];

  // bit registers, one word per group of 32 lines
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      men_q  <= '1;
      edge_q <= '0;
      pol_q  <= '0;
      for (int w = 0; w < NW; w++) begin
        auxa_q[w] <= '0;
        auxb_q[w] <= '0;
      end
    end else if (bus_wr) begin
      for (int w = 0; w < NW; w++) begin
        if (waddr == W_MASK + WIDX_W'(w))
          mask_q[w*DATA_W +: DATA_W] <= merge_word(mask_q[w*DATA_W +: DATA_W], bus_wdata, bus_be);
        if (waddr == W_MEN + WIDX_W'(w))
          men_q[w*DATA_W +: DATA_W] <= merge_word(men_q[w*DATA_W +: DATA_W], bus_wdata, bus_be);
        if (waddr == W_EDGE + WIDX_W'(w))
          edge_q[w*DATA_W +: DATA_W] <= merge_word(edge_q[w*DATA_W +: DATA_W], bus_wdata, bus_be);
        if (waddr == W_POL + WIDX_W'(w))
          pol_q[w*DATA_W +: DATA_W] <= merge_word(pol_q[w*DATA_W +: DATA_W], bus_wdata, bus_be);
        if (waddr == W_AUXA + WIDX_W'(w))
          auxa_q[w] <= merge_word(auxa_q[w], bus_wdata, bus_be);
        if (waddr == W_AUXB + WIDX_W'(w))
          auxb_q[w] <= merge_word(auxb_q[w], bus_wdata, bus_be);
      end
    end
  end

  // per-line byte storage
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int n = 0; n < N_IN; n++) begin
        route_q[n] <= '0;
        vec_q[n]   <= '0;
      end
    end else if (bus_wr) begin
      for (int n = 0; n < N_IN; n++) begin
        if (waddr == W_ROUTE + WIDX_W'(n / 4) && bus_be[n % 4])
          route_q[n] <= bus_wdata[(n % 4) * 8 +: 8];
        if (waddr == W_VEC + WIDX_W'(n / 4) && bus_be[n % 4])
          vec_q[n] <= bus_wdata[(n % 4) * 8 +: 8];
      end
    end
  end

  // write-one-to-clear pulse, not stored
  always_comb begin
    clr_o = '0;
    for (int w = 0; w < NW; w++) begin
      if (bus_wr && waddr == W_CLR + WIDX_W'(w))
        clr_o[w*DATA_W +: DATA_W] = bus_wdata & be_mask(bus_be);
    end
  end

  always_comb begin
    rmux = '0;
    if (waddr == W_ID + WIDX_W'(1)) rmux = {8'h00, ID_CNT, 16'h0000};
    for (int w = 0; w < NW; w++) begin
      if (waddr == W_MASK + WIDX_W'(w)) rmux = mask_q[w*DATA_W +: DATA_W];
      if (waddr == W_MEN  + WIDX_W'(w)) rmux = men_q[w*DATA_W +: DATA_W];
      if (waddr == W_EDGE + WIDX_W'(w)) rmux = edge_q[w*DATA_W +: DATA_W];
      if (waddr == W_POL  + WIDX_W'(w)) rmux = pol_q[w*DATA_W +: DATA_W];
      if (waddr == W_AUXA + WIDX_W'(w)) rmux = auxa_q[w];
      if (waddr == W_AUXB + WIDX_W'(w)) rmux = auxb_q[w];
    end
    for (int k = 0; k < N_IN / 4; k++) begin
      if (waddr == W_ROUTE + WIDX_W'(k))
        rmux = {route_q[4*k+3], route_q[4*k+2], route_q[4*k+1], route_q[4*k]};
      if (waddr == W_VEC + WIDX_W'(k))
        rmux = {vec_q[4*k+3], vec_q[4*k+2], vec_q[4*k+1], vec_q[4*k]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (bus_rd) rdata_q <= rmux;
  end

  assign bus_rdata = rdata_q;
  assign mask_o    = mask_q;
  assign men_o     = men_q;
  assign edge_o    = edge_q;
  assign pol_o     = pol_q;

  for (genvar n = 0; n < N_IN; n++) begin : g_vec
    assign vec_flat[n*8 +: 8] = vec_q[n];
  end

  // R6
  clr_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && waddr >= W_CLR && waddr < W_CLR + WIDX_W'(NW)) |=> (bus_rdata == '0));

  // R1
  id_word_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && waddr == W_ID + WIDX_W'(1)) |=> (bus_rdata[23:16] == ID_CNT));
endmodule

// File: rtl/wvec_ctrl.sv
module wvec_ctrl
  import wvec_pkg::*;
#(
  parameter int N_IN     = 64,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_IN-1:0]   irq_in,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [3:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              msg_valid,
  output logic [7:0]        msg_vector,
  input  logic              msg_ready
);
  logic [N_IN-1:0]   line_sync;
  logic [N_IN-1:0]   mask, men, edge_sel, pol_inv, clr_pulse, ack_pulse, req;
  logic [N_IN*8-1:0] vec_flat;

  wvec_sync #(.N_IN(N_IN), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d_async(irq_in), .d_sync(line_sync)
  );

  wvec_regs #(.N_IN(N_IN)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mask_o(mask), .men_o(men), .edge_o(edge_sel), .pol_o(pol_inv),
    .clr_o(clr_pulse), .vec_flat(vec_flat)
  );

  wvec_trig #(.N_IN(N_IN)) u_trig (
    .clk(clk), .rst(rst), .line_sync(line_sync), .edge_sel(edge_sel),
    .pol_inv(pol_inv), .clr_pulse(clr_pulse), .ack_pulse(ack_pulse), .req(req)
  );

  wvec_arb #(.N_IN(N_IN)) u_arb (
    .clk(clk), .rst(rst), .req(req), .mask(mask), .men(men), .vec_flat(vec_flat),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_vector(msg_vector),
    .ack_pulse(ack_pulse)
  );

  // R5
  single_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_pulse));

  // R7
  ack_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (|ack_pulse) |-> (msg_valid && msg_ready));
endmodule

// File: tb/tb_wvec_ctrl.sv
module tb_wvec_ctrl;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] irq_in = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        msg_valid;
  logic [7:0]  msg_vector;
  logic        msg_ready = 1'b0;

  int checks = 0, failures = 0, cyc = 0;
  logic [31:0] mask0 = '1, mask1 = '1, edge0 = '0, edge1 = '0, pol1 = '0;

  always #4 clk = ~clk;

  wvec_ctrl #(.N_IN(N)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_ready(msg_ready)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] vec_of(int n);
    return 8'(8'h40 + n);
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(logic [11:0] a, logic [31:0] exp, string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic get_msg(output bit got, output logic [7:0] v);
    got = 0; v = '0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (msg_valid) begin
        got = 1; v = msg_vector;
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
        break;
      end
    end
  endtask

  task automatic expect_msg(int n, string req);
    bit got; logic [7:0] v;
    get_msg(got, v);
    chk(got && v == vec_of(n), req, {23'b0, got, v}, {24'h000001, vec_of(n)});
  endtask

  task automatic expect_none(string req);
    msg_ready = 1'b0;
    repeat (10) @(negedge clk);
    chk(!msg_valid, req, {31'b0, msg_valid}, 32'h0);
  endtask

  task automatic drain;
    repeat (6) @(negedge clk);
    msg_ready = 1'b1;
    repeat (4) @(negedge clk);
    msg_ready = 1'b0;
  endtask

  task automatic pulse(logic [N-1:0] bits, bit to_high);
    @(negedge clk);
    if (to_high) irq_in = irq_in | bits; else irq_in = irq_in & ~bits;
    repeat (4) @(negedge clk);
    if (to_high) irq_in = irq_in & ~bits; else irq_in = irq_in | bits;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rd_chk(12'h020, 32'hFFFF_FFFF, "R1 mask word0");
    rd_chk(12'h024, 32'hFFFF_FFFF, "R1 mask word1");
    rd_chk(12'h044, 32'hFFFF_FFFF, "R1 msg-enable word1");
    rd_chk(12'h060, 32'h0, "R1 edge word0");
    rd_chk(12'h3E4, 32'h0, "R1 polarity word1");
    rd_chk(12'h004, 32'h003F_0000, "R1 id count");
    rd_chk(12'h000, 32'h0, "R1 id low word");
    chk(!msg_valid, "R1 no message after reset", {31'b0, msg_valid}, 32'h0);
  endtask

  task automatic t_vectors;
    for (int k = 0; k < N / 4; k++)
      wr(12'(12'h200 + 4 * k), {vec_of(4*k+3), vec_of(4*k+2), vec_of(4*k+1), vec_of(4*k)});
    wr(12'h204, 32'h0000_AA00, 4'b0010);
    rd_chk(12'h204, {vec_of(7), vec_of(6), 8'hAA, vec_of(4)}, "R8 byte-lane write");
    wr(12'h204, {24'h0, vec_of(5)} << 8, 4'b0010);
    rd_chk(12'h204, {vec_of(7), vec_of(6), vec_of(5), vec_of(4)}, "R8 byte restore");
  endtask

  task automatic t_level_high;
    mask0[5] = 1'b0; wr(12'h020, mask0);
    irq_in[5] = 1'b1;
    expect_msg(5, "R4 level high first");
    expect_msg(5, "R4 level high repeats");
    irq_in[5] = 1'b0;
    drain();
    expect_none("R4 level stops when inactive");
  endtask

  task automatic t_level_low;
    irq_in[40] = 1'b1;
    pol1[8] = 1'b1; wr(12'h3E4, pol1);
    mask1[8] = 1'b0; wr(12'h024, mask1);
    expect_none("R4 active-low idle high sends nothing");
    irq_in[40] = 1'b0;
    expect_msg(40, "R4 active-low level, R2 word1 bit8");
    irq_in[40] = 1'b1;
    drain();
    expect_none("R4 active-low released");
  endtask

  task automatic t_mask;
    irq_in[6] = 1'b1;
    expect_none("R3 masked level blocked");
    mask0[6] = 1'b0; wr(12'h020, mask0);
    expect_msg(6, "R3 unmask lets through");
    irq_in[6] = 1'b0;
    drain();
  endtask

  task automatic t_edges;
    edge1[1] = 1'b1; wr(12'h064, edge1);
    mask1[1] = 1'b0; wr(12'h024, mask1);
    pulse(64'd1 << 33, 1'b1);
    expect_msg(33, "R5 rising edge one message");
    expect_none("R5 pending cleared on accept");
    irq_in[34] = 1'b1;
    repeat (4) @(negedge clk);
    edge1[2] = 1'b1; wr(12'h064, edge1);
    pol1[2] = 1'b1; wr(12'h3E4, pol1);
    mask1[2] = 1'b0; wr(12'h024, mask1);
    expect_none("R5 falling idle high sends nothing");
    pulse(64'd1 << 34, 1'b0);
    expect_msg(34, "R5 falling edge one message");
    expect_none("R5 falling edge no repeat");
  endtask

  task automatic t_clear;
    edge0[10] = 1'b1; wr(12'h060, edge0);
    pulse(64'd1 << 10, 1'b1);
    wr(12'h080, 32'h0);
    mask0[10] = 1'b0; wr(12'h020, mask0);
    expect_msg(10, "R6 zero write keeps pending, R3 latched while masked");
    mask0[10] = 1'b1; wr(12'h020, mask0);
    pulse(64'd1 << 10, 1'b1);
    wr(12'h080, 32'h0000_0400);
    mask0[10] = 1'b0; wr(12'h020, mask0);
    expect_none("R6 one write discards pending");
    rd_chk(12'h080, 32'h0, "R6 clear reads zero");
  endtask

  task automatic t_enable;
    wr(12'h040, ~(32'd1 << 12));
    mask0[12] = 1'b0; wr(12'h020, mask0);
    irq_in[12] = 1'b1;
    expect_none("R7 message-enable 0 blocks");
    wr(12'h040, 32'hFFFF_FFFF);
    expect_msg(12, "R7 message-enable 1 passes");
    irq_in[12] = 1'b0;
    drain();
  endtask

  task automatic t_priority;
    logic [7:0] v0;
    edge0[20] = 1'b1; wr(12'h060, edge0);
    edge1[18] = 1'b1; wr(12'h064, edge1);
    mask0[20] = 1'b0; wr(12'h020, mask0);
    mask1[18] = 1'b0; wr(12'h024, mask1);
    pulse((64'd1 << 20) | (64'd1 << 50), 1'b1);
    chk(msg_valid, "R10 message offered", {31'b0, msg_valid}, 32'h1);
    v0 = msg_vector;
    repeat (3) @(negedge clk);
    chk(msg_valid && msg_vector == v0, "R10 held stable without ready",
        {23'b0, msg_valid, msg_vector}, {24'h000001, v0});
    expect_msg(20, "R9 lowest line first");
    expect_msg(50, "R9 higher line next");
    expect_none("R9 both served once");
  endtask

  task automatic t_storage;
    wr(12'h110, 32'h1234_5678);
    rd_chk(12'h110, 32'h1234_5678, "R11 route bytes storage");
    wr(12'h0C4, 32'hCAFE_0001);
    rd_chk(12'h0C4, 32'hCAFE_0001, "R11 aux word storage");
    rd_chk(12'h300, 32'h0, "R11 unmapped reads zero");
    expect_none("R11 storage writes send nothing");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_vectors();
    t_level_high();
    t_level_low();
    t_mask();
    t_edges();
    t_clear();
    t_enable();
    t_priority();
    t_storage();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule